// File: doc/BRIEF.md
# Write-Back Ownership Snooping Cache Controller

This block is the coherence controller of one processor's private, direct-mapped, write-back cache on a shared-bus multiprocessor. Each line is tracked as Invalid, Shared (clean copy) or Modified (dirty copy that only this cache owns). Processor stores never write main memory directly. Before a store completes, the controller becomes the only owner of the line. If it already holds a clean copy, it broadcasts an invalidate. On a store miss it issues a read-for-ownership. A dirty victim is written back to memory before a new fill is requested.

The controller also watches the requests that other agents place on the bus. When it owns a matching Modified line, it answers the request itself. It raises an intervention signal that keeps main memory silent and drives the line data. A snooped read leaves the line Shared, because memory takes the same transfer. A snooped read-for-ownership hands the data and ownership to the requester and invalidates the local copy. The processor holds its request until `cpu_ready`. The bus arbiter raises `bus_gnt` for exactly the cycle in which the request is carried out, and no snooped transaction is presented in a cycle granted to this cache.

Top module: `coh_wb_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 00; Shared is 01, Modified is 10), so the first access to any address misses, and `bus_req`, `cpu_ready` and `snp_intervene` stay low while no request or snoop is presented.
- R2: A load that misses requests bus command read (code 01) at `cpu_addr`. In the granted cycle, `cpu_ready` is high and `cpu_rdata` equals `bus_rdata`, and the line becomes Shared with that data.
- R3: A load that hits a Shared or Modified line is answered in the cycle it is presented, with the line data and without a bus request.
- R4: A store that misses with a clean or empty victim requests read-for-ownership (code 10) at `cpu_addr`. In the granted cycle it completes, and the line becomes Modified, holding the store data.
- R5: A store that hits a Shared line requests invalidate (code 11) with no data fetch. In the granted cycle it completes, and the line becomes Modified, holding the store data.
- R6: A store that hits a Modified line completes in the cycle it is presented without a bus request, and it replaces the line data.
- R7: A miss whose victim line is Modified first requests write-back (code 00), with the victim's address on `bus_addr` and its data on `bus_wdata`. After that grant the victim is Invalid, and the miss goes on to issue its fill request.
- R8: A snooped read (code 01) that matches a Modified line raises `snp_intervene` in the same cycle, with the line data on `snp_data`. The line then becomes Shared.
- R9: A snooped read-for-ownership (code 10) that matches a Modified line raises `snp_intervene` with the line data, and the line then becomes Invalid.
- R10: A snooped invalidate (code 11) or read-for-ownership that matches a Shared line makes it Invalid without raising `snp_intervene`.
- R11: A snoop acts only when its address matches a valid local line. A snooped write-back (code 00), a tag mismatch, or a snoop presented while `bus_gnt` is high changes no line and raises no intervention.
- R12: In a cycle with `snp_valid` high, a processor hit does not complete, and a store hit does not modify the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Access completes in this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| bus_req | output | 1 | Own bus request |
| bus_cmd | output | 2 | Own command: 00 write-back, 01 read, 10 read-for-ownership, 11 invalidate |
| bus_addr | output | ADDR_W | Own request address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Own request is carried out this cycle |
| bus_rdata | input | DATA_W | Fill data from memory or an intervening owner |
| snp_valid | input | 1 | Another agent's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_intervene | output | 1 | This cache supplies the data; memory must not answer |
| snp_data | output | DATA_W | Data supplied on intervention |

## Verification
The bench builds the controller with four lines, 8-bit addresses and 16-bit data. With only four indices, addresses that differ only in their tag collide at once. This brings dirty-victim write-back, re-fills after a snoop has taken a line, and snoops that just miss on the tag within reach of short directed sequences. A random phase then mixes loads, stores, grants and snoops over a small pool of tags. The same pool makes every ownership transition recur many times.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'b00,
    LN_SHR = 2'b01,
    LN_MOD = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    BC_WB  = 2'b00,
    BC_RD  = 2'b01,
    BC_RFO = 2'b10,
    BC_INV = 2'b11
  } bus_cmd_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_e          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_e          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_st_e          wr_st,
  input  logic              wr_tag_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data
);
  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q[g] <= LN_INV;
      else if (sel) st_q[g] <= wr_st;
    end

    always_ff @(posedge clk) begin
      if (sel && wr_tag_en)  tag_q[g]  <= wr_tag;
      if (sel && wr_data_en) data_q[g] <= wr_data;
    end
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];
endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
  import coh_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic             snp_valid,
  input  bus_cmd_e         snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic             bus_gnt,
  input  line_st_e         ln_st,
  input  logic [TAG_W-1:0] ln_tag,
  output logic             intervene,
  output logic             upd_en,
  output line_st_e         upd_st
);
  logic match;

  always_comb begin
    match     = snp_valid && !bus_gnt && (ln_st != LN_INV) && (ln_tag == snp_tag);
    intervene = match && (ln_st == LN_MOD) && ((snp_cmd == BC_RD) || (snp_cmd == BC_RFO));
    upd_en    = 1'b0;
    upd_st    = ln_st;
    if (match) begin
      unique case (snp_cmd)
        BC_RD: begin
          if (ln_st == LN_MOD) begin
            upd_en = 1'b1;
            upd_st = LN_SHR;
          end
        end
        BC_RFO, BC_INV: begin
          upd_en = 1'b1;
          upd_st = LN_INV;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/coh_req.sv
module coh_req
  import coh_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [TAG_W-1:0]  cpu_tag,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              snp_valid,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  line_st_e          ln_st,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              req,
  output bus_cmd_e          cmd,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              upd_en,
  output line_st_e          upd_st,
  output logic              upd_tag_en,
  output logic              upd_data_en,
  output logic [DATA_W-1:0] upd_data
);
  logic hit, hit_ok, victim_dirty, granted;

  always_comb begin
    hit          = (ln_st != LN_INV) && (ln_tag == cpu_tag);
    hit_ok       = hit && (!cpu_we || (ln_st == LN_MOD));
    victim_dirty = (ln_st == LN_MOD) && !hit;

    if (hit && cpu_we)  cmd = BC_INV;
    else if (victim_dirty) cmd = BC_WB;
    else if (cpu_we)    cmd = BC_RFO;
    else                cmd = BC_RD;

    req     = cpu_req && !hit_ok;
    granted = req && bus_gnt;
    ready   = cpu_req && ((hit_ok && !snp_valid) || (granted && (cmd != BC_WB)));
    rdata   = granted ? bus_rdata : ln_data;

    upd_en      = 1'b0;
    upd_st      = ln_st;
    upd_tag_en  = 1'b0;
    upd_data_en = 1'b0;
    upd_data    = cpu_wdata;
    if (granted) begin
      upd_en = 1'b1;
      unique case (cmd)
        BC_WB:  upd_st = LN_INV;
        BC_INV: begin
          upd_st      = LN_MOD;
          upd_data_en = 1'b1;
        end
        BC_RD: begin
          upd_st      = LN_SHR;
          upd_tag_en  = 1'b1;
          upd_data_en = 1'b1;
          upd_data    = bus_rdata;
        end
        BC_RFO: begin
          upd_st      = LN_MOD;
          upd_tag_en  = 1'b1;
          upd_data_en = 1'b1;
        end
        default: ;
      endcase
    end else if (cpu_req && hit_ok && cpu_we && !snp_valid) begin
      upd_en      = 1'b1;
      upd_st      = LN_MOD;
      upd_data_en = 1'b1;
    end
  end
endmodule

// File: rtl/coh_wb_ctrl.sv
module coh_wb_ctrl
  import coh_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_intervene,
  output logic [DATA_W-1:0] snp_data
);
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic [IDX_W-1:0]  c_idx, s_idx;
  logic [TAG_W-1:0]  c_tag, s_tag;
  line_st_e          c_st, s_st;
  logic [TAG_W-1:0]  c_ln_tag, s_ln_tag;
  logic [DATA_W-1:0] c_ln_data, s_ln_data;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  bus_cmd_e          own_cmd;
  logic              own_en, own_tag_en, own_data_en;
  line_st_e          own_st;
  logic [DATA_W-1:0] own_data;
  logic              snp_en;
  line_st_e          snp_st;

  coh_req #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_req (
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_tag     (c_tag),
    .cpu_wdata   (cpu_wdata),
    .snp_valid   (snp_valid),
    .bus_gnt     (bus_gnt),
    .bus_rdata   (bus_rdata),
    .ln_st       (c_st),
    .ln_tag      (c_ln_tag),
    .ln_data     (c_ln_data),
    .req         (bus_req),
    .cmd         (own_cmd),
    .ready       (cpu_ready),
    .rdata       (cpu_rdata),
    .upd_en      (own_en),
    .upd_st      (own_st),
    .upd_tag_en  (own_tag_en),
    .upd_data_en (own_data_en),
    .upd_data    (own_data)
  );

  coh_snoop #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (bus_cmd_e'(snp_cmd)),
    .snp_tag   (s_tag),
    .bus_gnt   (bus_gnt),
    .ln_st     (s_st),
    .ln_tag    (s_ln_tag),
    .intervene (snp_intervene),
    .upd_en    (snp_en),
    .upd_st    (snp_st)
  );

  logic              wr_en, wr_tag_en, wr_data_en;
  logic [IDX_W-1:0]  wr_idx;
  line_st_e          wr_st;

  always_comb begin
    wr_en      = own_en || snp_en;
    wr_idx     = own_en ? c_idx : s_idx;
    wr_st      = own_en ? own_st : snp_st;
    wr_tag_en  = own_en && own_tag_en;
    wr_data_en = own_en && own_data_en;
  end

  coh_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .a_idx      (c_idx),
    .a_st       (c_st),
    .a_tag      (c_ln_tag),
    .a_data     (c_ln_data),
    .b_idx      (s_idx),
    .b_st       (s_st),
    .b_tag      (s_ln_tag),
    .b_data     (s_ln_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_st      (wr_st),
    .wr_tag_en  (wr_tag_en),
    .wr_tag     (c_tag),
    .wr_data_en (wr_data_en),
    .wr_data    (own_data)
  );

  assign bus_cmd   = own_cmd;
  assign bus_addr  = (own_cmd == BC_WB) ? {c_ln_tag, c_idx} : cpu_addr;
  assign bus_wdata = (own_cmd == BC_WB) ? c_ln_data : '0;
  assign snp_data  = s_ln_data;

  // R2
  rd_only_for_load_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_req && bus_cmd == BC_RD) |-> !cpu_we);

  // R4
  rfo_only_for_store_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_req && bus_cmd == BC_RFO) |-> cpu_we);

  // R7
  wb_victim_addr_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_req && bus_cmd == BC_WB) |->
      (bus_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]) && (bus_addr != cpu_addr));

  // R3
  hit_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cpu_ready && !bus_gnt) |-> !bus_req);

  // R12
  snoop_stalls_hit_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (snp_valid && !bus_gnt) |-> !cpu_ready);

  // R8
  rd_snoop_downgrade_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (snp_valid && snp_intervene && snp_cmd == BC_RD && !cpu_ready) |=>
      (!(snp_valid && !bus_gnt && snp_cmd == BC_RD && snp_addr == $past(snp_addr))
       || !snp_intervene));

  // R9
  rfo_snoop_release_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (snp_valid && snp_intervene && snp_cmd == BC_RFO && !cpu_ready) |=>
      (!(snp_valid && snp_addr == $past(snp_addr)) || !snp_intervene));
endmodule

// File: tb/coh_wb_ctrl_tb.sv
module coh_wb_ctrl_tb;
  localparam int LINES  = 4;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int IW     = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cpu_req, cpu_we;
  logic [ADDR_W-1:0] cpu_addr;
  logic [DATA_W-1:0] cpu_wdata;
  logic              cpu_ready;
  logic [DATA_W-1:0] cpu_rdata;
  logic              bus_req;
  logic [1:0]        bus_cmd;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic              bus_gnt;
  logic [DATA_W-1:0] bus_rdata;
  logic              snp_valid;
  logic [1:0]        snp_cmd;
  logic [ADDR_W-1:0] snp_addr;
  logic              snp_intervene;
  logic [DATA_W-1:0] snp_data;

  always #4 clk = ~clk;

  coh_wb_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (.*);

  // behavioural model: 0 invalid, 1 shared, 2 modified
  int m_st [LINES];
  int m_tag[LINES];
  int m_dat[LINES];

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  bit e_req, e_ready, e_int;
  int e_cmd, e_baddr, e_bwdata, e_rdata, e_sdata;

  task automatic predict();
    int ci, ct, si, st;
    bit hit, ok;
    ci = int'(cpu_addr) % LINES; ct = int'(cpu_addr) / LINES;
    si = int'(snp_addr) % LINES; st = int'(snp_addr) / LINES;
    hit = (m_st[ci] != 0) && (m_tag[ci] == ct);
    ok  = hit && (!cpu_we || m_st[ci] == 2);
    if (hit && cpu_we)        e_cmd = 3;
    else if (m_st[ci] == 2)   e_cmd = 0;
    else if (cpu_we)          e_cmd = 2;
    else                      e_cmd = 1;
    e_req    = cpu_req && !ok;
    e_baddr  = (e_cmd == 0) ? m_tag[ci] * LINES + ci : int'(cpu_addr);
    e_bwdata = (e_cmd == 0) ? m_dat[ci] : 0;
    e_ready  = cpu_req && ((ok && !snp_valid) || (e_req && bus_gnt && e_cmd != 0));
    e_rdata  = (e_req && bus_gnt) ? int'(bus_rdata) : m_dat[ci];
    e_int    = snp_valid && !bus_gnt && m_st[si] == 2 && m_tag[si] == st &&
               (snp_cmd == 2'b01 || snp_cmd == 2'b10);
    e_sdata  = m_dat[si];
  endtask

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic advance_model();
    int ci, ct, si, st;
    bit hit;
    ci = int'(cpu_addr) % LINES; ct = int'(cpu_addr) / LINES;
    si = int'(snp_addr) % LINES; st = int'(snp_addr) / LINES;
    hit = (m_st[ci] != 0) && (m_tag[ci] == ct);
    if (e_req && bus_gnt) begin
      case (e_cmd)
        0: m_st[ci] = 0;
        1: begin m_st[ci] = 1; m_tag[ci] = ct; m_dat[ci] = int'(bus_rdata); end
        2: begin m_st[ci] = 2; m_tag[ci] = ct; m_dat[ci] = int'(cpu_wdata); end
        default: begin m_st[ci] = 2; m_dat[ci] = int'(cpu_wdata); end
      endcase
    end else if (snp_valid && !bus_gnt) begin
      if (m_st[si] != 0 && m_tag[si] == st) begin
        if (snp_cmd == 2'b01 && m_st[si] == 2) m_st[si] = 1;
        else if (snp_cmd == 2'b10 || snp_cmd == 2'b11) m_st[si] = 0;
      end
    end else if (cpu_req && cpu_we && hit && m_st[ci] == 2) begin
      m_dat[ci] = int'(cpu_wdata);
    end
  endtask

  // compare every output against the model, then move to the next cycle
  task automatic step();
    #1;
    predict();
    chk("bus_req", int'(bus_req), int'(e_req));
    chk("cpu_ready", int'(cpu_ready), int'(e_ready));
    chk("snp_intervene", int'(snp_intervene), int'(e_int));
    if (e_req) begin
      chk("bus_cmd", int'(bus_cmd), e_cmd);
      chk("bus_addr", int'(bus_addr), e_baddr);
      if (e_cmd == 0) chk("bus_wdata", int'(bus_wdata), e_bwdata);
    end
    if (e_ready && !cpu_we) chk("cpu_rdata", int'(cpu_rdata), e_rdata);
    if (e_int) chk("snp_data", int'(snp_data), e_sdata);
    advance_model();
    @(negedge clk);
  endtask

  task automatic idle();
    cpu_req = 0; cpu_we = 0; bus_gnt = 0; snp_valid = 0;
  endtask

  task automatic cpu(bit we, int a, int d, bit g, int rd);
    cpu_req = 1; cpu_we = we; cpu_addr = ADDR_W'(a); cpu_wdata = DATA_W'(d);
    bus_gnt = g; bus_rdata = DATA_W'(rd); snp_valid = 0;
    step();
  endtask

  task automatic snoop(int c, int a);
    cpu_req = 0; bus_gnt = 0; snp_valid = 1; snp_cmd = 2'(c); snp_addr = ADDR_W'(a);
    step();
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
    rst_n = 0; idle(); cpu_addr = '0; cpu_wdata = '0; bus_rdata = '0;
    snp_cmd = '0; snp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    cur_req = "R1"; idle(); step();
    cpu(0, 8'h05, 0, 0, 0);
    cur_req = "R2"; cpu(0, 8'h05, 0, 1, 16'hAAAA);
    cur_req = "R3"; cpu(0, 8'h05, 0, 0, 0);
    cur_req = "R5"; cpu(1, 8'h05, 16'h1234, 0, 0);
    cpu(1, 8'h05, 16'h1234, 1, 0);
    cur_req = "R3"; cpu(0, 8'h05, 0, 0, 0);
    cur_req = "R6"; cpu(1, 8'h05, 16'h5678, 0, 0);
    cpu(0, 8'h05, 0, 0, 0);
    cur_req = "R7"; cpu(0, 8'h45, 0, 0, 0);
    cpu(0, 8'h45, 0, 1, 0);
    cpu(0, 8'h45, 0, 1, 16'hBEEF);
    cur_req = "R4"; cpu(1, 8'h12, 16'h0F0F, 0, 0);
    cpu(1, 8'h12, 16'h0F0F, 1, 0);
    cpu(0, 8'h12, 0, 0, 0);
    cur_req = "R8"; snoop(1, 8'h12); snoop(1, 8'h12);
    cpu(1, 8'h12, 16'h7777, 0, 0);
    cpu(1, 8'h12, 16'h7777, 1, 0);
    cur_req = "R11"; snoop(0, 8'h12); snoop(1, 8'h52); snoop(2, 8'h32);
    cpu_req = 0; snp_valid = 1; snp_cmd = 2'b10; snp_addr = 8'h12; bus_gnt = 1; step();
    cpu(0, 8'h12, 0, 0, 0);
    cur_req = "R9"; snoop(2, 8'h12); snoop(2, 8'h12);
    cpu(0, 8'h12, 0, 0, 0);
    cur_req = "R10"; snoop(3, 8'h45); cpu(0, 8'h45, 0, 0, 0);
    cpu(0, 8'h45, 0, 1, 16'h4545);
    snoop(2, 8'h45); cpu(0, 8'h45, 0, 0, 0);
    cur_req = "R12";
    cpu(1, 8'h03, 16'h3333, 0, 0); cpu(1, 8'h03, 16'h3333, 1, 0);
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h03; cpu_wdata = 16'h9999;
    bus_gnt = 0; snp_valid = 1; snp_cmd = 2'b00; snp_addr = 8'h01; step();
    cpu_req = 1; cpu_we = 0; snp_valid = 1; step();
    idle(); snoop(1, 8'h03);

    cur_req = "R7";
    for (int n = 0; n < 3000; n++) begin
      cpu_req   = ($urandom % 4) != 0;
      cpu_we    = $urandom % 2;
      cpu_addr  = ADDR_W'(($urandom % 3) * LINES + ($urandom % LINES));
      cpu_wdata = DATA_W'($urandom);
      bus_rdata = DATA_W'($urandom);
      snp_valid = ($urandom % 4) == 0;
      snp_cmd   = 2'($urandom);
      snp_addr  = ADDR_W'(($urandom % 3) * LINES + ($urandom % LINES));
      bus_gnt   = 0;
      predict();
      bus_gnt   = e_req && ($urandom % 2);
      if (bus_gnt) snp_valid = 0;
      step();
    end

    idle(); step();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule